// File: doc/BRIEF.md
# Serial configuration readback controller

The block reads stored configuration frames out of a frame memory and sends them one bit per rising edge of the configuration clock on a single serial output. A 0-then-1 start-bit pair goes before each frame so that a receiver can find frame boundaries. The data bits of a frame follow, most-significant first. A readback runs through consecutive frame addresses up to the last frame. At the end the controller returns to idle, holds the output high and raises a done flag for one cycle.

There are two ways to start a readback. The first is the falling edge of an active-low request pin, which always starts at frame 0. The pin must stay low for the whole transfer; raising it aborts the transfer. A new start from the pin is armed only after the pin has been high for at least two clock edges. The second is a host path. While the host enable is high, the pin is ignored, and a host go strobe starts a readback at a host-supplied frame index.

A two-bit permission policy decides whether a start is accepted: never, once per reset, or without limit. Frame memory is read with one cycle of latency. The word for a frame is fetched during that frame's start-bit pair, so no gap separates the header from the data.

Top module: `cfg_readback_ctrl`

## Requirements
- R1: Policy encoding: 2'b00 and 2'b11 refuse every start, so `busy` stays 0 and `sdo` stays 1. 2'b10 accepts any number of readbacks.
- R2: With policy 2'b01, the first accepted start sets a flag that only reset clears. Every later start is refused and leaves `sdo` high. After a reset one readback is accepted again.
- R3: A start event is an edge e that samples `req_n` low after the pin was sampled high on at least the two previous edges, or an edge that samples `host_go` high while `host_en` is high. After e, `busy` is 1 and `sdo` is 1 for LAT cycles. The first start bit (0) is on `sdo` in the cycle that begins at edge e+LAT.
- R4: During a pin-started readback, an edge that samples `req_n` high aborts it. From the next cycle `busy` is 0, `sdo` is 1, and `done` stays 0.
- R5: Driving `req_n` low again after it was high for only one edge starts nothing. High on two or more edges followed by low restarts the readback from frame 0.
- R6: Each frame occupies FBITS+2 consecutive cycles on `sdo`, with one bit per cycle: 0, then 1, then the frame word from bit FBITS-1 down to bit 0. Frames follow one another with no idle cycle between them.
- R7: Frames are sent at consecutive addresses, from the start frame up to FRAMES-1. The start frame is 0 for a pin start and `host_start` for a host start.
- R8: While `host_en` is 1, `req_n` has no effect: it neither starts nor aborts a readback. A host start with `host_start` >= FRAMES is refused. Host starts are subject to the policy of R1 and R2.
- R9: In the cycle after the last data bit, `done` is 1, `busy` is 0 and `sdo` is 1. `done` is 0 in the cycle after that.
- R10: `mem_rd_en` is 1 for exactly one cycle per frame: the cycle of that frame's 0 start bit, with `mem_addr` equal to the frame index. `mem_rdata` is expected on the following cycle.
- R11: While and after reset, before any start, `sdo`=1, `done`=0, `busy`=0 and `mem_rd_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_n | input | 1 | Active-low readback request pin |
| policy | input | 2 | Readback permission policy |
| host_en | input | 1 | Host path enable; the pin is ignored while high |
| host_go | input | 1 | Host start strobe |
| host_start | input | FA | Host start frame index |
| mem_rd_en | output | 1 | Frame memory read enable |
| mem_addr | output | FA | Frame memory address |
| mem_rdata | input | FBITS | Frame word, valid one cycle after the read |
| sdo | output | 1 | Serial readback data, high when idle |
| done | output | 1 | One-cycle pulse after the last frame |
| busy | output | 1 | Readback in progress |

## Verification
Every result has a fixed due cycle relative to the edge that samples the stimulus:

| Result | Due |
|---|---|
| `busy` rises | the cycle after the start edge |
| first start bit | LAT cycles after the start edge |
| memory word | used one cycle after its read |
| abort | idle from the cycle after the high sample |
| `done` | the cycle after the last data bit |

The bench drives inputs just after falling edges and samples at the following falling edges, so it counts rising edges exactly. It checks the whole expected stream for each start frame and each memory pattern against a bit sequence computed from the frame index and a seed.

// File: rtl/rb_pkg.sv
package rb_pkg;

  typedef enum logic [1:0] {
    POL_NONE = 2'b00,
    POL_ONCE = 2'b01,
    POL_ANY  = 2'b10,
    POL_RSVD = 2'b11
  } rb_policy_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_HDR0,
    ST_HDR1,
    ST_DATA
  } rb_state_e;

  // start is permitted by policy given the once-used flag
  function automatic logic policy_allows(input logic [1:0] pol, input logic used);
    return (pol == POL_ANY) || ((pol == POL_ONCE) && !used);
  endfunction

  // saturating count of consecutive high samples of the request pin
  function automatic logic [1:0] high_count_next(input logic [1:0] cnt, input logic pin_high);
    if (!pin_high) return 2'd0;
    return (cnt == 2'd2) ? 2'd2 : cnt + 2'd1;
  endfunction

  function automatic logic frame_in_range(input int idx, input int frames);
    return idx < frames;
  endfunction

endpackage

// File: rtl/rb_req_detect.sv
module rb_req_detect (
  input  logic cfg_clk,
  input  logic rst_n,
  input  logic req_n,
  input  logic host_en,
  output logic pin_start_evt
);
  import rb_pkg::*;

  logic [1:0] hi_cnt;

  always_ff @(posedge cfg_clk) begin
    if (!rst_n) hi_cnt <= 2'd0;
    else        hi_cnt <= high_count_next(hi_cnt, req_n);
  end

  // falling edge after at least two high samples, pin path not overridden
  assign pin_start_evt = !req_n && (hi_cnt == 2'd2) && !host_en;

endmodule

// File: rtl/rb_policy_gate.sv
module rb_policy_gate (
  input  logic       cfg_clk,
  input  logic       rst_n,
  input  logic [1:0] policy,
  input  logic       start_req,
  input  logic       idle,
  output logic       grant,
  output logic       once_used
);
  import rb_pkg::*;

  assign grant = start_req && idle && policy_allows(policy, once_used);

  always_ff @(posedge cfg_clk) begin
    if (!rst_n)                          once_used <= 1'b0;
    else if (grant && policy == POL_ONCE) once_used <= 1'b1;
  end

endmodule

// File: rtl/rb_serializer.sv
module rb_serializer #(
  parameter int FRAMES = 4,
  parameter int FBITS  = 8,
  parameter int LAT    = 2,
  parameter int FA     = 2
) (
  input  logic             cfg_clk,
  input  logic             rst_n,
  input  logic             grant,
  input  logic [FA-1:0]    start_frame,
  input  logic             start_pin,
  input  logic             req_n,
  input  logic             host_en,
  input  logic [FBITS-1:0] mem_rdata,
  output logic             mem_rd_en,
  output logic [FA-1:0]    mem_addr,
  output logic             sdo,
  output logic             done,
  output logic             busy,
  output logic             src_pin,
  output logic             abort_evt,
  output logic             hdr0_phase,
  output logic             hdr1_phase
);
  import rb_pkg::*;

  localparam int BW = $clog2(FBITS);
  localparam int LW = $clog2(LAT + 1);
  localparam logic [FA-1:0] LAST_F = FA'(FRAMES - 1);

  rb_state_e        state;
  logic [FA-1:0]    frame;
  logic [LW-1:0]    wcnt;
  logic [BW-1:0]    bcnt;
  logic [FBITS-1:0] shreg;

  assign busy       = (state != ST_IDLE);
  assign hdr0_phase = (state == ST_HDR0);
  assign hdr1_phase = (state == ST_HDR1);
  assign abort_evt  = busy && src_pin && !host_en && req_n;
  assign mem_rd_en  = hdr0_phase;
  assign mem_addr   = frame;

  always_comb begin
    case (state)
      ST_HDR0: sdo = 1'b0;
      ST_HDR1: sdo = 1'b1;
      ST_DATA: sdo = shreg[FBITS-1];
      default: sdo = 1'b1;
    endcase
  end

  always_ff @(posedge cfg_clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      frame   <= '0;
      wcnt    <= '0;
      bcnt    <= '0;
      shreg   <= '0;
      done    <= 1'b0;
      src_pin <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort_evt) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: if (grant) begin
            state   <= ST_WAIT;
            frame   <= start_frame;
            src_pin <= start_pin;
            wcnt    <= LW'(LAT - 1);
          end
          ST_WAIT: if (wcnt == '0) state <= ST_HDR0;
                   else            wcnt  <= wcnt - 1'b1;
          ST_HDR0: state <= ST_HDR1;
          ST_HDR1: begin
            shreg <= mem_rdata;
            bcnt  <= BW'(FBITS - 1);
            state <= ST_DATA;
          end
          ST_DATA: if (bcnt == '0) begin
            if (frame == LAST_F) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              frame <= frame + 1'b1;
              state <= ST_HDR0;
            end
          end else begin
            bcnt  <= bcnt - 1'b1;
            shreg <= {shreg[FBITS-2:0], 1'b0};
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/cfg_readback_ctrl.sv
module cfg_readback_ctrl #(
  parameter int FRAMES = 4,
  parameter int FBITS  = 8,
  parameter int LAT    = 2,
  parameter int FA     = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
  input  logic             cfg_clk,
  input  logic             rst_n,
  input  logic             req_n,
  input  logic [1:0]       policy,
  input  logic             host_en,
  input  logic             host_go,
  input  logic [FA-1:0]    host_start,
  output logic             mem_rd_en,
  output logic [FA-1:0]    mem_addr,
  input  logic [FBITS-1:0] mem_rdata,
  output logic             sdo,
  output logic             done,
  output logic             busy
);
  import rb_pkg::*;

  logic          pin_start_evt;
  logic          host_start_evt;
  logic          start_req;
  logic          grant;
  logic          once_used;
  logic          src_pin;
  logic          abort_evt;
  logic          hdr0_phase;
  logic          hdr1_phase;
  logic [FA-1:0] start_frame;

  rb_req_detect u_req (
    .cfg_clk       (cfg_clk),
    .rst_n         (rst_n),
    .req_n         (req_n),
    .host_en       (host_en),
    .pin_start_evt (pin_start_evt)
  );

  assign host_start_evt = host_en && host_go && frame_in_range(int'(host_start), FRAMES);
  assign start_req      = pin_start_evt || host_start_evt;
  assign start_frame    = pin_start_evt ? '0 : host_start;

  rb_policy_gate u_pol (
    .cfg_clk   (cfg_clk),
    .rst_n     (rst_n),
    .policy    (policy),
    .start_req (start_req),
    .idle      (!busy),
    .grant     (grant),
    .once_used (once_used)
  );

  rb_serializer #(
    .FRAMES (FRAMES),
    .FBITS  (FBITS),
    .LAT    (LAT),
    .FA     (FA)
  ) u_ser (
    .cfg_clk     (cfg_clk),
    .rst_n       (rst_n),
    .grant       (grant),
    .start_frame (start_frame),
    .start_pin   (pin_start_evt),
    .req_n       (req_n),
    .host_en     (host_en),
    .mem_rdata   (mem_rdata),
    .mem_rd_en   (mem_rd_en),
    .mem_addr    (mem_addr),
    .sdo         (sdo),
    .done        (done),
    .busy        (busy),
    .src_pin     (src_pin),
    .abort_evt   (abort_evt),
    .hdr0_phase  (hdr0_phase),
    .hdr1_phase  (hdr1_phase)
  );

endmodule

// File: rtl/rb_checker.sv
module rb_checker (
  input logic       cfg_clk,
  input logic       rst_n,
  input logic [1:0] policy,
  input logic       host_en,
  input logic       host_go,
  input logic       sdo,
  input logic       done,
  input logic       busy,
  input logic       mem_rd_en,
  input logic       pin_start_evt,
  input logic       grant,
  input logic       abort_evt,
  input logic       hdr0_phase,
  input logic       hdr1_phase,
  input logic       once_used
);

  p_refuse_r1: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (!busy && pin_start_evt && (policy == 2'b00 || policy == 2'b11)) |=> !busy);

  p_once_sticky_r2: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    once_used |=> once_used);

  p_once_refuse_r2: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (!busy && once_used && policy == 2'b01) |=> !busy);

  p_start_r3: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    grant |=> (busy && sdo));

  p_abort_r4: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    abort_evt |=> (!busy && !done && sdo));

  p_hdr_zero_r6: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    hdr0_phase |-> !sdo);

  p_hdr_one_r6: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    hdr0_phase |=> (hdr1_phase && sdo));

  p_host_owns_r8: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (!busy && host_en && !host_go) |=> !busy);

  p_done_pulse_r9: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    done |-> (!busy && sdo));

  p_mem_single_r10: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  p_idle_high_r11: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    !busy |-> sdo);

endmodule

bind cfg_readback_ctrl rb_checker u_chk (.*);

// File: tb/sim_cfg_readback_ctrl.sv
`timescale 1ns/1ps
module sim_cfg_readback_ctrl;

  localparam int FRAMES = 4;
  localparam int FBITS  = 8;
  localparam int LAT    = 3;
  localparam int FA     = 2;

  logic             cfg_clk = 1'b0;
  logic             rst_n;
  logic             req_n;
  logic [1:0]       policy;
  logic             host_en;
  logic             host_go;
  logic [FA-1:0]    host_start;
  logic             mem_rd_en;
  logic [FA-1:0]    mem_addr;
  logic [FBITS-1:0] mem_rdata = '0;
  logic             sdo;
  logic             done;
  logic             busy;

  int nvec = 0;
  int nbad = 0;
  int seed = 1;

  always #2.5 cfg_clk = ~cfg_clk;

  cfg_readback_ctrl #(.FRAMES(FRAMES), .FBITS(FBITS), .LAT(LAT)) u0 (
    .cfg_clk(cfg_clk), .rst_n(rst_n), .req_n(req_n), .policy(policy),
    .host_en(host_en), .host_go(host_go), .host_start(host_start),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .sdo(sdo), .done(done), .busy(busy)
  );

  function automatic logic [FBITS-1:0] pat(input int f);
    return FBITS'(seed * 29 + f * 77) ^ 8'hC3;
  endfunction

  always @(posedge cfg_clk) if (mem_rd_en) mem_rdata <= pat(int'(mem_addr));

  task automatic check(input string req, input int act, input int exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // caller has just driven a start at a falling edge; edge e is the next rising edge
  task automatic expect_stream(input int first, input string tag);
    int bad = 0;
    int bad_mem = 0;
    logic [FBITS-1:0] w;
    for (int k = 1; k <= LAT; k++) begin
      @(negedge cfg_clk);
      host_go = 1'b0;
      if (!(busy === 1'b1 && sdo === 1'b1)) bad++;
    end
    check({tag, " R3 latency idle-high"}, bad, 0);
    bad = 0;
    for (int f = first; f < FRAMES; f++) begin
      @(negedge cfg_clk);
      if (sdo !== 1'b0) bad++;
      if (!(mem_rd_en === 1'b1 && int'(mem_addr) == f)) bad_mem++;
      @(negedge cfg_clk);
      if (sdo !== 1'b1) bad++;
      if (mem_rd_en !== 1'b0) bad_mem++;
      w = pat(f);
      for (int b = FBITS - 1; b >= 0; b--) begin
        @(negedge cfg_clk);
        if (sdo !== w[b]) bad++;
        if (mem_rd_en !== 1'b0) bad_mem++;
      end
    end
    check({tag, " R6 R7 stream mismatches"}, bad, 0);
    check({tag, " R10 memory reads"}, bad_mem, 0);
    @(negedge cfg_clk);
    check({tag, " R9 done/busy/sdo"}, {done, busy, sdo}, 3'b101);
    @(negedge cfg_clk);
    check({tag, " R9 done one cycle"}, done, 0);
  endtask

  // observe n cycles that must stay idle
  task automatic expect_idle(input int n, input string tag);
    int bad = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge cfg_clk);
      host_go = 1'b0;
      if (!(busy === 1'b0 && sdo === 1'b1 && done === 1'b0)) bad++;
    end
    check(tag, bad, 0);
  endtask

  task automatic pin_release(input int n);
    req_n = 1'b1;
    repeat (n) @(negedge cfg_clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge cfg_clk);
    rst_n = 1'b1;
    @(negedge cfg_clk);
  endtask

  initial begin
    repeat (100000) @(posedge cfg_clk);
    nbad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    req_n = 1'b1; policy = 2'b10; host_en = 1'b0; host_go = 1'b0; host_start = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge cfg_clk);
    check("R11 reset outputs", {sdo, done, busy, mem_rd_en}, 4'b1000);
    rst_n = 1'b1;
    repeat (3) @(negedge cfg_clk);
    check("R11 after reset", {sdo, done, busy, mem_rd_en}, 4'b1000);

    // R1 unlimited: repeated pin readbacks with several memory patterns
    for (int s = 1; s <= 4; s++) begin
      seed = s * 37;
      req_n = 1'b0;
      expect_stream(0, "R1 unlimited pin");
      pin_release(3);
    end

    // R4 abort, then R5 short high pulse and proper restart
    seed = 5;
    req_n = 1'b0;
    repeat (LAT + 5) @(negedge cfg_clk);
    check("R4 active before abort", busy, 1);
    req_n = 1'b1;
    @(negedge cfg_clk);
    check("R4 abort", {busy, sdo, done}, 3'b010);
    req_n = 1'b0;
    expect_idle(LAT + 12, "R5 short high does not restart");
    req_n = 1'b1;
    repeat (2) @(negedge cfg_clk);
    req_n = 1'b0;
    expect_stream(0, "R5 restart");
    pin_release(3);

    // R1 prohibit codes
    policy = 2'b00;
    req_n = 1'b0;
    expect_idle(LAT + 20, "R1 policy 00 refuses");
    pin_release(3);
    policy = 2'b11;
    req_n = 1'b0;
    expect_idle(LAT + 20, "R1 policy 11 refuses");
    pin_release(3);

    // R2 once per reset
    policy = 2'b01;
    seed = 9;
    req_n = 1'b0;
    expect_stream(0, "R2 first once");
    pin_release(3);
    req_n = 1'b0;
    expect_idle(LAT + 20, "R2 second refused");
    pin_release(3);
    host_en = 1'b1; host_start = 2'd1; host_go = 1'b1;
    expect_idle(LAT + 20, "R2 host refused after once");
    host_en = 1'b0;
    do_reset();
    pin_release(3);
    req_n = 1'b0;
    expect_stream(0, "R2 once after reset");
    pin_release(3);

    // R8 host path
    policy = 2'b10;
    host_en = 1'b1;
    req_n = 1'b0;
    expect_idle(LAT + 12, "R8 pin ignored when host enabled");
    for (int s = 0; s < FRAMES; s++) begin
      seed = 11 + s;
      req_n = (s % 2 == 0) ? 1'b1 : 1'b0;
      host_start = FA'(s); host_go = 1'b1;
      expect_stream(s, "R8 R7 host start");
    end
    req_n = 1'b1;
    host_en = 1'b0; host_go = 1'b1; host_start = 2'd2;
    expect_idle(LAT + 10, "R8 host_go ignored when disabled");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule